// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block decides when an SDRAM controller must spend a cycle on an auto refresh. The memory needs 4096 auto refreshes in every 64 ms. The scheduler turns that into a fixed average interval, computed from a clock-frequency parameter. At 133 MHz the interval is floor(64 ms / 4096 x 133 MHz) = 2078 cycles. Each expiry of the interval adds one refresh to a backlog. The backlog may hold up to eight postponed refreshes, so a busy command sequencer can delay them and catch up later.

The link to the command sequencer works like a valid/ready stream of refresh commands. The scheduler raises `ref_req` (valid) while the backlog is non-zero and no lockout is running. The sequencer raises `ref_ready` once it can give up the bus. Before it does, it closes any open rows with a precharge-all, because an auto refresh may only start when every bank is precharged. `banks_idle` reports that state.

A refresh is issued in any cycle where all three signals are high. In that cycle `ref_issue` pulses and the sequencer drives the auto-refresh command. No precharge is needed afterwards, because the refresh closes the banks itself. While `ref_ready` or `banks_idle` is low, the request waits and nothing is lost. Back-pressure only grows the backlog. If the backlog is already full when the interval expires again, the sticky `overdue_err` flag is raised.

Each refresh is followed by a lockout that lasts one row cycle time, rounded up to whole clocks (65 ns gives 9 cycles at 133 MHz). During the lockout `cmd_block` forbids every other command. After reset, two refreshes are already pending. `init_done`, which releases normal traffic, rises only when both have been issued and the second lockout has ended.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset, `pending_cnt` is 2, `ref_req` is 1, and `init_done`, `cmd_block`, `overdue_err` and `ref_issue` are 0.
- R2: The backlog gains one refresh every INTERVAL cycles, where INTERVAL = floor(WINDOW_MS x CLK_FREQ_KHZ / ROWS_PER_WINDOW) (2078 at the defaults). The first gain comes INTERVAL cycles after reset is released.
- R3: `ref_issue` is high for exactly the cycles in which `ref_req`, `ref_ready` and `banks_idle` are all high. Each issue lowers the backlog by one in the next cycle.
- R4: After an issue in cycle t, `cmd_block` is high in cycles t+1 to t+RC-1, where RC = ceil(TRC_PS x CLK_FREQ_KHZ / 1e9) (9 at the defaults). The next issue can come no earlier than t+RC.
- R5: `ref_req` is high exactly when `pending_cnt` is non-zero and `cmd_block` is low.
- R6: `pending_cnt` never exceeds MAX_POSTPONE (8). If the interval expires while the count is at 8 and no refresh is issued, `overdue_err` goes high and stays high until reset.
- R7: `ref_urgent` is high exactly when `pending_cnt` equals MAX_POSTPONE.
- R8: `init_done` is low until two refreshes have been issued and the lockout after the second has ended (it rises in cycle t2+RC after the second issue at t2). Once high, it stays high.
- R9: When the interval expires in the same cycle as an issue, `pending_cnt` is unchanged.
- R10: While `ref_ready` or `banks_idle` is low, no refresh is issued and the backlog is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_ready | input | 1 | Sequencer can accept a refresh (ready) |
| banks_idle | input | 1 | All banks are precharged |
| ref_req | output | 1 | Refresh wanted (valid) |
| ref_issue | output | 1 | Auto-refresh command is issued this cycle |
| ref_urgent | output | 1 | Backlog full, further delay becomes overdue |
| cmd_block | output | 1 | Post-refresh lockout, no command allowed |
| init_done | output | 1 | Start-up refreshes finished, traffic released |
| overdue_err | output | 1 | Sticky: a refresh was lost to a full backlog |
| pending_cnt | output | $clog2(MAX_POSTPONE+1) | Number of refreshes owed |

## Verification
The assertions check on every cycle:
- the exact spacing between interval expiries;
- that the lockout lasts RC cycles from each issue;
- that no request is raised during a lockout;
- that the backlog stays within its bound and falls by one on a plain issue;
- that a simultaneous expiry and issue leaves the backlog unchanged;
- that `overdue_err` and `init_done` are sticky.

Only the bench scenarios can show the rest: how the backlog behaves under back-pressure from the sequencer or the banks, the start-up release timing, the fill to eight and the overdue event, and the drain that follows.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

  // Average refresh spacing in clocks: window(ms) * f(kHz) / rows.
  function automatic longint unsigned refresh_interval_cycles(
    input longint unsigned f_khz,
    input longint unsigned window_ms,
    input longint unsigned rows
  );
    return (window_ms * f_khz) / rows;
  endfunction

  // Row-cycle lockout in clocks, rounded up: ps * kHz / 1e9.
  function automatic longint unsigned row_cycle_clocks(
    input longint unsigned trc_ps,
    input longint unsigned f_khz
  );
    longint unsigned prod;
    prod = trc_ps * f_khz;
    return (prod + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction

  // Event applied to the refresh backlog in one cycle.
  typedef enum logic [1:0] {
    EV_HOLD = 2'd0,
    EV_ADD  = 2'd1,
    EV_SUB  = 2'd2
  } backlog_ev_e;

endpackage

// File: rtl/sdram_ref_interval.sv
module sdram_ref_interval #(
  parameter int unsigned PERIOD = 2078
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] RELOAD = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
    end else if (cnt_q == '0) begin
      cnt_q <= RELOAD;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick = (cnt_q == '0);
endmodule

// File: rtl/sdram_ref_backlog.sv
module sdram_ref_backlog
  import sdram_ref_pkg::*;
#(
  parameter int unsigned MAX_PEND  = 8,
  parameter int unsigned INIT_PEND = 2,
  parameter int unsigned PW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          take,
  output logic [PW-1:0] pend,
  output logic          urgent,
  output logic          overdue
);
  localparam logic [PW-1:0] PMAX  = PW'(MAX_PEND);
  localparam logic [PW-1:0] PINIT = PW'(INIT_PEND);

  backlog_ev_e ev;
  logic [PW-1:0] pend_q;
  logic          over_q;

  always_comb begin
    if (tick && !take) begin
      ev = EV_ADD;
    end else if (take && !tick) begin
      ev = EV_SUB;
    end else begin
      ev = EV_HOLD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= PINIT;
      over_q <= 1'b0;
    end else begin
      unique case (ev)
        EV_ADD: begin
          if (pend_q == PMAX) begin
            over_q <= 1'b1;
          end else begin
            pend_q <= pend_q + 1'b1;
          end
        end
        EV_SUB: begin
          if (pend_q != '0) begin
            pend_q <= pend_q - 1'b1;
          end
        end
        default: begin
          pend_q <= pend_q;
        end
      endcase
    end
  end

  assign pend    = pend_q;
  assign urgent  = (pend_q == PMAX);
  assign overdue = over_q;
endmodule

// File: rtl/sdram_ref_lockout.sv
module sdram_ref_lockout #(
  parameter int unsigned RC_CYC = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic busy
);
  generate
    if (RC_CYC <= 1) begin : g_none
      assign busy = 1'b0;
    end else begin : g_cnt
      localparam int unsigned LW = (RC_CYC > 2) ? $clog2(RC_CYC) : 1;
      localparam logic [LW-1:0] LOAD = LW'(RC_CYC - 1);
      logic [LW-1:0] left_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          left_q <= '0;
        end else if (fire) begin
          left_q <= LOAD;
        end else if (left_q != '0) begin
          left_q <= left_q - 1'b1;
        end
      end

      assign busy = (left_q != '0);
    end
  endgenerate
endmodule

// File: rtl/sdram_ref_init_gate.sv
module sdram_ref_init_gate #(
  parameter int unsigned INIT_CNT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic busy,
  output logic released
);
  generate
    if (INIT_CNT == 0) begin : g_free
      assign released = 1'b1;
    end else begin : g_count
      localparam int unsigned IW = $clog2(INIT_CNT + 1);
      localparam logic [IW-1:0] TARGET = IW'(INIT_CNT);
      logic [IW-1:0] cnt_q;
      logic          done_q;
      logic          seen_all;

      assign seen_all = (cnt_q == TARGET);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q  <= '0;
          done_q <= 1'b0;
        end else begin
          if (fire && !seen_all) begin
            cnt_q <= cnt_q + 1'b1;
          end
          if (seen_all && !busy) begin
            done_q <= 1'b1;
          end
        end
      end

      assign released = done_q | (seen_all & ~busy);
    end
  endgenerate
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdram_ref_pkg::*;
#(
  parameter int unsigned CLK_FREQ_KHZ    = 133000,
  parameter int unsigned WINDOW_MS       = 64,
  parameter int unsigned ROWS_PER_WINDOW = 4096,
  parameter int unsigned TRC_PS          = 65000,
  parameter int unsigned MAX_POSTPONE    = 8,
  parameter int unsigned INIT_REFRESHES  = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ref_ready,
  input  logic                                banks_idle,
  output logic                                ref_req,
  output logic                                ref_issue,
  output logic                                ref_urgent,
  output logic                                cmd_block,
  output logic                                init_done,
  output logic                                overdue_err,
  output logic [$clog2(MAX_POSTPONE+1)-1:0]   pending_cnt
);
  localparam int unsigned INTERVAL_CYC =
    int'(refresh_interval_cycles(64'(CLK_FREQ_KHZ), 64'(WINDOW_MS), 64'(ROWS_PER_WINDOW)));
  localparam int unsigned RC_CYC =
    int'(row_cycle_clocks(64'(TRC_PS), 64'(CLK_FREQ_KHZ)));
  localparam int unsigned PW = $clog2(MAX_POSTPONE + 1);

  logic          interval_tick;
  logic          lock_busy;
  logic          fire;
  logic [PW-1:0] backlog;

  sdram_ref_interval #(.PERIOD(INTERVAL_CYC)) u_interval (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (interval_tick)
  );

  sdram_ref_backlog #(
    .MAX_PEND (MAX_POSTPONE),
    .INIT_PEND(INIT_REFRESHES),
    .PW       (PW)
  ) u_backlog (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (interval_tick),
    .take   (fire),
    .pend   (backlog),
    .urgent (ref_urgent),
    .overdue(overdue_err)
  );

  sdram_ref_lockout #(.RC_CYC(RC_CYC)) u_lockout (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (fire),
    .busy (lock_busy)
  );

  sdram_ref_init_gate #(.INIT_CNT(INIT_REFRESHES)) u_init (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .busy    (lock_busy),
    .released(init_done)
  );

  // Valid while refreshes are owed and the row-cycle lockout is over.
  assign ref_req     = (backlog != '0) && !lock_busy;
  // Transfer needs the sequencer ready and every bank precharged.
  assign fire        = ref_req && ref_ready && banks_idle;
  assign ref_issue   = fire;
  assign cmd_block   = lock_busy;
  assign pending_cnt = backlog;
endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk
  import sdram_ref_pkg::*;
#(
  parameter int unsigned CLK_FREQ_KHZ    = 133000,
  parameter int unsigned WINDOW_MS       = 64,
  parameter int unsigned ROWS_PER_WINDOW = 4096,
  parameter int unsigned TRC_PS          = 65000,
  parameter int unsigned MAX_POSTPONE    = 8
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              ref_req,
  input logic                              ref_issue,
  input logic                              ref_urgent,
  input logic                              cmd_block,
  input logic                              init_done,
  input logic                              overdue_err,
  input logic [$clog2(MAX_POSTPONE+1)-1:0] pending_cnt,
  input logic                              interval_tick
);
  localparam int unsigned INTERVAL_CYC =
    int'(refresh_interval_cycles(64'(CLK_FREQ_KHZ), 64'(WINDOW_MS), 64'(ROWS_PER_WINDOW)));
  localparam int unsigned RC_CYC =
    int'(row_cycle_clocks(64'(TRC_PS), 64'(CLK_FREQ_KHZ)));

  int unsigned gap_q;
  int unsigned since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= 0;
    end else if (interval_tick) begin
      gap_q <= 0;
    end else begin
      gap_q <= gap_q + 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= 0;
    end else if (ref_issue) begin
      since_q <= 1;
    end else if (since_q != 0 && since_q < RC_CYC + 2) begin
      since_q <= since_q + 1;
    end
  end

  assert_interval_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    interval_tick |-> gap_q == INTERVAL_CYC - 1);

  assert_lockout_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_block) |-> since_q == RC_CYC);

  assert_no_req_in_lockout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_block |-> !ref_req);

  assert_issue_drains_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_issue && !interval_tick) |=> pending_cnt == $past(pending_cnt) - 1'b1);

  assert_tick_and_issue_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_issue && interval_tick) |=> $stable(pending_cnt));

  assert_pending_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pending_cnt <= ($clog2(MAX_POSTPONE+1))'(MAX_POSTPONE));

  assert_overdue_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overdue_err |=> overdue_err);

  assert_overdue_from_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overdue_err) |-> $past(ref_urgent));

  assert_release_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(
  .CLK_FREQ_KHZ   (CLK_FREQ_KHZ),
  .WINDOW_MS      (WINDOW_MS),
  .ROWS_PER_WINDOW(ROWS_PER_WINDOW),
  .TRC_PS         (TRC_PS),
  .MAX_POSTPONE   (MAX_POSTPONE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ref_req      (ref_req),
  .ref_issue    (ref_issue),
  .ref_urgent   (ref_urgent),
  .cmd_block    (cmd_block),
  .init_done    (init_done),
  .overdue_err  (overdue_err),
  .pending_cnt  (pending_cnt),
  .interval_tick(interval_tick)
);

// File: tb/sdram_refresh_sched_tb.sv
module sdram_refresh_sched_tb;
  localparam int CLK_PERIOD   = 10;
  localparam int EXP_INTERVAL = 2078; // floor(64 * 133000 / 4096)
  localparam int EXP_RC       = 9;    // ceil(65000 * 133000 / 1e9)
  localparam int EXP_MAX      = 8;
  localparam int EXP_INIT     = 2;
  localparam int WATCHDOG     = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_ready = 1'b0;
  logic       banks_idle = 1'b0;
  logic       ref_req, ref_issue, ref_urgent, cmd_block, init_done, overdue_err;
  logic [3:0] pending_cnt;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_refresh_sched u_dut (
    .clk(clk), .rst_n(rst_n), .ref_ready(ref_ready), .banks_idle(banks_idle),
    .ref_req(ref_req), .ref_issue(ref_issue), .ref_urgent(ref_urgent),
    .cmd_block(cmd_block), .init_done(init_done), .overdue_err(overdue_err),
    .pending_cnt(pending_cnt)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced once per cycle at the falling edge.
  int m_pend, m_gap, m_lock, m_init;
  bit m_done, m_over;

  always @(negedge clk) begin
    bit e_req, e_issue, tick;
    if (!rst_n) begin
      m_pend = EXP_INIT; m_gap = 0; m_lock = 0; m_init = 0; m_done = 0; m_over = 0;
    end else begin
      e_req   = (m_pend > 0) && (m_lock == 0);
      e_issue = e_req && ref_ready && banks_idle;
      check("R5", "ref_req", ref_req, e_req);
      check("R3", "ref_issue", ref_issue, e_issue);
      check("R4", "cmd_block", cmd_block, m_lock > 0);
      check("R7", "ref_urgent", ref_urgent, m_pend == EXP_MAX);
      check("R8", "init_done", init_done, m_done || (m_init >= EXP_INIT && m_lock == 0));
      check("R6", "overdue_err", overdue_err, m_over);
      check("R2", "pending_cnt", pending_cnt, m_pend);
      tick  = (m_gap == EXP_INTERVAL - 1);
      m_gap = tick ? 0 : m_gap + 1;
      if (m_init >= EXP_INIT && m_lock == 0) m_done = 1;
      if (e_issue) m_init++;
      if (e_issue) m_lock = EXP_RC - 1;
      else if (m_lock > 0) m_lock--;
      if (tick && !e_issue) begin
        if (m_pend == EXP_MAX) m_over = 1;
        else m_pend++;
      end else if (e_issue && !tick) begin
        m_pend--;
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    int first_i, second_i, done_i, n_issue;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check("R1", "reset pending", pending_cnt, 2);
    check("R1", "reset ref_req", ref_req, 1);
    check("R1", "reset init_done", init_done, 0);
    check("R1", "reset cmd_block", cmd_block, 0);
    check("R1", "reset overdue", overdue_err, 0);
    check("R1", "reset issue", ref_issue, 0);

    // R10: sequencer not ready, then banks not idle
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R10", "issue while not ready", ref_issue, 0);
    end
    check("R10", "backlog kept (not ready)", pending_cnt, 2);
    step();
    ref_ready = 1'b1;
    banks_idle = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R10", "issue while banks open", ref_issue, 0);
    end
    check("R10", "backlog kept (banks open)", pending_cnt, 2);

    // R3 R4 R8: start-up refresh pair and traffic release
    step();
    banks_idle = 1'b1;
    first_i = -1; second_i = -1; done_i = -1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ref_issue && first_i < 0) first_i = i;
      else if (ref_issue && second_i < 0) second_i = i;
      if (init_done && done_i < 0) done_i = i;
    end
    check("R3", "first init issue cycle", first_i, 0);
    check("R4", "gap between init issues", second_i - first_i, EXP_RC);
    check("R8", "release after second lockout", done_i - second_i, EXP_RC);
    check("R3", "backlog empty after init", pending_cnt, 0);

    // R2: steady refresh, one per interval
    n_issue = 0;
    for (int i = 0; i < 2 * EXP_INTERVAL; i++) begin
      @(negedge clk);
      if (ref_issue) n_issue++;
    end
    check("R2", "refreshes in two intervals", n_issue, 2);

    // R9: expiry and issue in the same cycle
    step();
    ref_ready = 1'b0;
    do @(negedge clk); while (pending_cnt != 1);
    do step(); while (m_gap != EXP_INTERVAL - 1);
    ref_ready = 1'b1;
    @(negedge clk);
    check("R9", "issue on expiry cycle", ref_issue, 1);
    @(negedge clk);
    check("R9", "backlog unchanged", pending_cnt, 1);
    repeat (EXP_RC + 3) @(negedge clk);
    check("R3", "backlog drained", pending_cnt, 0);

    // R6 R7: fill to the bound, then overflow
    step();
    ref_ready = 1'b0;
    do @(negedge clk); while (!ref_urgent);
    check("R7", "urgent at full backlog", pending_cnt, EXP_MAX);
    check("R6", "no overdue at full", overdue_err, 0);
    do @(negedge clk); while (!overdue_err);
    check("R6", "backlog saturated", pending_cnt, EXP_MAX);
    step();
    ref_ready = 1'b1;
    repeat (EXP_MAX * EXP_RC + 3) @(negedge clk);
    check("R3", "full backlog drained", pending_cnt, 0);
    check("R6", "overdue sticky", overdue_err, 1);
    check("R7", "urgent cleared", ref_urgent, 0);
    check("R8", "release sticky", init_done, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule